// File: doc/BRIEF.md
# Undocumented Immediate Combination ALU

This block is a purely combinational execution slice for the undocumented immediate-operand and load-both instructions of an 8-bit accumulator CPU. The sequencer presents the opcode, the operand byte (the immediate value, or the byte already read from memory for the load-both forms), the accumulator, the X index register and the processor status byte. The block returns the new accumulator, the new X and the new status byte, plus a flag that says whether the opcode belongs to its set. When the opcode is not its own, every output repeats its input, so the slice can sit on a shared writeback path without muxing.

Most of the instructions chain an AND of the accumulator with a second step: a shift, a rotate through carry or a subtract without borrow. Each has its own carry and overflow rule. Two unstable forms OR the accumulator with a build-time constant before the AND; that constant is the parameter `MAGIC`, which defaults to FF. Memory access and instruction sequencing belong to other blocks.

The status byte uses a fixed layout: bit 7 N, bit 6 V, bit 1 Z, bit 0 C. Bits 5 to 2 are carried through unchanged.

Top module: `combo_imm_alu`

## Requirements
- R1: Opcodes 0B and 2B set A to A AND operand. They set N and Z from that result and copy its bit 7 into C.
- R2: Opcode 4B forms t = A AND operand. It sets A to t shifted right by one place with a zero in bit 7, and C to bit 0 of t. N and Z come from the new A.
- R3: Opcode 6B forms t = A AND operand. It sets A to t rotated right with the incoming C in bit 7. C then takes bit 6 of the new A, and V takes bit 6 XOR bit 5 of the new A. N and Z come from the new A.
- R4: Opcode CB forms t = A AND X. It sets X to (t minus operand) mod 256 and leaves A unchanged. C is 1 when t >= operand, unsigned. N and Z come from the new X. The incoming C has no effect on the result.
- R5: Opcode 8B sets A to (A OR MAGIC) AND X AND operand, and sets N and Z from it. X is unchanged.
- R6: Opcode AB sets both A and X to (A OR MAGIC) AND operand, and sets N and Z from it.
- R7: Opcodes A3, A7, AF, B3, B7 and BF set both A and X to the operand byte, and set N and Z from it.
- R8: Opcode EB performs binary subtract with borrow: A = A - operand - (1 - C). C is the inverse of the borrow out, and V is the signed overflow. N and Z come from the new A. The decimal-mode bit (status bit 3) has no effect.
- R9: For any opcode outside the sets in R1 to R8, hit_o is 0 and A, X and the status byte pass through unchanged. For opcodes in those sets, hit_o is 1.
- R10: Status bits 5 to 2 always pass through unchanged. V changes only for opcodes 6B and EB, and C does not change for opcodes 8B, AB and the R7 set.
- R11: MAGIC defaults to FF. With the default, opcode 8B gives X AND operand and opcode AB gives operand, whatever A is. With MAGIC = 00, both use A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 8 | Opcode |
| opnd_i | input | 8 | Operand byte (immediate or fetched value) |
| a_i | input | 8 | Accumulator before the instruction |
| x_i | input | 8 | X register before the instruction |
| flags_i | input | 8 | Status byte before the instruction (N7 V6 Z1 C0) |
| a_o | output | 8 | Accumulator after the instruction |
| x_o | output | 8 | X register after the instruction |
| flags_o | output | 8 | Status byte after the instruction |
| hit_o | output | 1 | Opcode belongs to this unit |

## Verification
The sweeps target the carry and overflow rules that differ between the chained forms. If ALR took carry after the shift, C would always be 0. If ARR used ordinary rotate carry, C would follow bit 0 of t rather than bit 6 of the result. If AXS took a borrow from the incoming carry, X would be off by one whenever C is clear. If EB honoured the decimal bit, it would give adjusted results for BCD operands.

The bench also sweeps all 256 opcodes with odd register values, to catch a decoder that claims or drops an opcode. A second instance built with MAGIC = 00 shows whether the unstable forms really depend on the parameter and not on a hard-wired FF.

// File: rtl/combo_imm_alu.sv
module combo_imm_alu #(
  parameter logic [7:0] MAGIC = 8'hFF
) (
  input  logic [7:0] op_i,
  input  logic [7:0] opnd_i,
  input  logic [7:0] a_i,
  input  logic [7:0] x_i,
  input  logic [7:0] flags_i,
  output logic [7:0] a_o,
  output logic [7:0] x_o,
  output logic [7:0] flags_o,
  output logic       hit_o
);
  localparam int FN = 7;
  localparam int FV = 6;
  localparam int FZ = 1;
  localparam int FC = 0;

  logic       c_in;
  logic [7:0] a_and_m;
  logic [7:0] a_and_x;
  logic [7:0] ror_v;
  logic [8:0] axs_d;
  logic [8:0] sbc_s;
  logic [7:0] unst;

  assign c_in    = flags_i[FC];
  assign a_and_m = a_i & opnd_i;
  assign a_and_x = a_i & x_i;
  assign ror_v   = {c_in, a_and_m[7:1]};
  assign axs_d   = {1'b0, a_and_x} - {1'b0, opnd_i};
  assign sbc_s   = {1'b0, a_i} + {1'b0, ~opnd_i} + {8'd0, c_in};
  assign unst    = (a_i | MAGIC) & opnd_i;

  function automatic logic [7:0] nz(input logic [7:0] f, input logic [7:0] v);
    logic [7:0] r;
    r     = f;
    r[FN] = v[7];
    r[FZ] = (v == 8'd0);
    return r;
  endfunction

  always_comb begin
    a_o     = a_i;
    x_o     = x_i;
    flags_o = flags_i;
    hit_o   = 1'b1;
    case (op_i)
      8'h0B, 8'h2B: begin
        a_o         = a_and_m;
        flags_o     = nz(flags_i, a_and_m);
        flags_o[FC] = a_and_m[7];
      end
      8'h4B: begin
        a_o         = {1'b0, a_and_m[7:1]};
        flags_o     = nz(flags_i, {1'b0, a_and_m[7:1]});
        flags_o[FC] = a_and_m[0];
      end
      8'h6B: begin
        a_o         = ror_v;
        flags_o     = nz(flags_i, ror_v);
        flags_o[FC] = ror_v[6];
        flags_o[FV] = ror_v[6] ^ ror_v[5];
      end
      8'hCB: begin
        x_o         = axs_d[7:0];
        flags_o     = nz(flags_i, axs_d[7:0]);
        flags_o[FC] = ~axs_d[8];
      end
      8'h8B: begin
        a_o     = unst & x_i;
        flags_o = nz(flags_i, unst & x_i);
      end
      8'hAB: begin
        a_o     = unst;
        x_o     = unst;
        flags_o = nz(flags_i, unst);
      end
      8'hA3, 8'hA7, 8'hAF, 8'hB3, 8'hB7, 8'hBF: begin
        a_o     = opnd_i;
        x_o     = opnd_i;
        flags_o = nz(flags_i, opnd_i);
      end
      8'hEB: begin
        a_o         = sbc_s[7:0];
        flags_o     = nz(flags_i, sbc_s[7:0]);
        flags_o[FC] = sbc_s[8];
        flags_o[FV] = (a_i[7] ^ opnd_i[7]) & (a_i[7] ^ sbc_s[7]);
      end
      default: hit_o = 1'b0;
    endcase
  end
endmodule

module combo_imm_alu_chk (
  input logic [7:0] op_i,
  input logic [7:0] opnd_i,
  input logic [7:0] a_i,
  input logic [7:0] x_i,
  input logic [7:0] flags_i,
  input logic [7:0] a_o,
  input logic [7:0] x_o,
  input logic [7:0] flags_o,
  input logic       hit_o
);
  logic known;
  assign known = !$isunknown({op_i, opnd_i, a_i, x_i, flags_i});

  always_comb begin
    if (known) begin
      p_keep_mid_bits_r10: assert (flags_o[5:2] == flags_i[5:2]);
      if (!hit_o)
        p_miss_passthru_r9: assert (a_o == a_i && x_o == x_i && flags_o == flags_i);
      if (op_i == 8'h0B || op_i == 8'h2B)
        p_anc_carry_sign_r1: assert (flags_o[0] == a_o[7] && flags_o[7] == a_o[7]);
      if (op_i == 8'h4B)
        p_alr_top_clear_r2: assert (a_o[7] == 1'b0 && flags_o[7] == 1'b0);
      if (op_i == 8'h6B)
        p_arr_cv_link_r3: assert (flags_o[6] == (flags_o[0] ^ a_o[5]) && a_o[7] == flags_i[0]);
      if (op_i == 8'hCB)
        p_axs_keeps_a_r4: assert (a_o == a_i && flags_o[6] == flags_i[6]);
      if (op_i == 8'h8B)
        p_xaa_subset_r5: assert ((a_o & ~(x_i & opnd_i)) == 8'd0 && x_o == x_i);
      if (op_i == 8'hAB)
        p_lxa_pair_r6: assert (a_o == x_o && (a_o & ~opnd_i) == 8'd0);
      if (op_i == 8'hA3 || op_i == 8'hA7 || op_i == 8'hAF ||
          op_i == 8'hB3 || op_i == 8'hB7 || op_i == 8'hBF)
        p_lax_both_r7: assert (a_o == opnd_i && x_o == opnd_i && flags_o[0] == flags_i[0]);
      if (op_i == 8'hEB)
        p_sbc_zero_r8: assert (flags_o[1] == (a_o == 8'd0) && x_o == x_i);
    end
  end
endmodule

bind combo_imm_alu combo_imm_alu_chk u_chk (
  .op_i(op_i), .opnd_i(opnd_i), .a_i(a_i), .x_i(x_i), .flags_i(flags_i),
  .a_o(a_o), .x_o(x_o), .flags_o(flags_o), .hit_o(hit_o)
);

// File: tb/tb_combo_imm_alu.sv
`timescale 1ns/1ps
module tb_combo_imm_alu;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] op, opnd, a, x, fl;
  logic [7:0] a_o, x_o, f_o, a_o2, x_o2, f_o2;
  logic       hit, hit2;

  int n_chk = 0;
  int n_bad = 0;

  combo_imm_alu dut (
    .op_i(op), .opnd_i(opnd), .a_i(a), .x_i(x), .flags_i(fl),
    .a_o(a_o), .x_o(x_o), .flags_o(f_o), .hit_o(hit)
  );

  combo_imm_alu #(.MAGIC(8'h00)) dut_m0 (
    .op_i(op), .opnd_i(opnd), .a_i(a), .x_i(x), .flags_i(fl),
    .a_o(a_o2), .x_o(x_o2), .flags_o(f_o2), .hit_o(hit2)
  );

  function automatic logic [7:0] setnz(input logic [7:0] f, input int v);
    logic [7:0] r;
    r = f;
    r[7] = ((v & 128) != 0);
    r[1] = ((v & 255) == 0);
    return r;
  endfunction

  function automatic logic [24:0] model(input logic [7:0] o, input logic [7:0] m,
      input logic [7:0] av, input logic [7:0] xv, input logic [7:0] f, input logic [7:0] mg);
    int ai, mi, xi, ci, t, r, d;
    logic [7:0] na, nx, nf;
    logic h;
    ai = int'(av); mi = int'(m); xi = int'(xv); ci = int'(f[0]);
    na = av; nx = xv; nf = f; h = 1'b1;
    case (o)
      8'h0B, 8'h2B: begin t = ai & mi; na = 8'(t); nf = setnz(f, t); nf[0] = (t >= 128); end
      8'h4B: begin t = ai & mi; r = t / 2; na = 8'(r); nf = setnz(f, r); nf[0] = (t % 2 == 1); end
      8'h6B: begin
        t = ai & mi; r = t / 2 + 128 * ci; na = 8'(r); nf = setnz(f, r);
        nf[0] = ((r / 64) % 2 == 1);
        nf[6] = (((r / 64) % 2) != ((r / 32) % 2));
      end
      8'hCB: begin
        t = ai & xi; d = t - mi; nx = 8'((d + 256) % 256);
        nf = setnz(f, (d + 256) % 256); nf[0] = (t >= mi);
      end
      8'h8B: begin t = (ai | int'(mg)) & xi & mi; na = 8'(t); nf = setnz(f, t); end
      8'hAB: begin t = (ai | int'(mg)) & mi; na = 8'(t); nx = 8'(t); nf = setnz(f, t); end
      8'hA3, 8'hA7, 8'hAF, 8'hB3, 8'hB7, 8'hBF: begin na = m; nx = m; nf = setnz(f, mi); end
      8'hEB: begin
        int sa, sm, sd;
        d  = ai - mi - (1 - ci);
        na = 8'((d + 512) % 256);
        nf = setnz(f, (d + 512) % 256);
        nf[0] = (d >= 0);
        sa = (ai >= 128) ? ai - 256 : ai;
        sm = (mi >= 128) ? mi - 256 : mi;
        sd = sa - sm - (1 - ci);
        nf[6] = (sd < -128 || sd > 127);
      end
      default: h = 1'b0;
    endcase
    return {h, na, nx, nf};
  endfunction

  function automatic string tag(input logic [7:0] o);
    case (o)
      8'h0B, 8'h2B: return "R1";
      8'h4B: return "R2";
      8'h6B: return "R3";
      8'hCB: return "R4";
      8'h8B: return "R5";
      8'hAB: return "R6";
      8'hA3, 8'hA7, 8'hAF, 8'hB3, 8'hB7, 8'hBF: return "R7";
      8'hEB: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [7:0] o, input logic [7:0] m, input logic [7:0] av,
                       input logic [7:0] xv, input logic [7:0] f, input string t);
    logic [24:0] e, g;
    op = o; opnd = m; a = av; x = xv; fl = f;
    #1;
    e = model(o, m, av, xv, f, 8'hFF);
    g = {hit, a_o, x_o, f_o};
    n_chk++;
    if (g !== e || f_o[5:2] !== f[5:2]) begin
      n_bad++;
      $display("FAIL %s op=%h m=%h a=%h x=%h f=%h: got hit/a/x/f=%h expected %h (R10 mid bits kept)",
               t, o, m, av, xv, f, g, e);
    end
  endtask

  task automatic apply_m0(input logic [7:0] o, input logic [7:0] m, input logic [7:0] av,
                          input logic [7:0] xv, input logic [7:0] f);
    logic [24:0] e, g;
    op = o; opnd = m; a = av; x = xv; fl = f;
    #1;
    e = model(o, m, av, xv, f, 8'h00);
    g = {hit2, a_o2, x_o2, f_o2};
    n_chk++;
    if (g !== e) begin
      n_bad++;
      $display("FAIL R11 MAGIC=00 op=%h m=%h a=%h x=%h: got %h expected %h", o, m, av, xv, g, e);
    end
  endtask

  initial begin
    #100000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] ops [14];
    ops = '{8'h0B, 8'h2B, 8'h4B, 8'h6B, 8'hCB, 8'h8B, 8'hAB,
            8'hA3, 8'hA7, 8'hAF, 8'hB3, 8'hB7, 8'hBF, 8'hEB};
    @(negedge clk);

    // R1..R8, R10: per-opcode sweeps of A with a spread of operands, both carries, D set on odd passes
    for (int k = 0; k < 14; k++)
      for (int av = 0; av < 256; av++)
        for (int mi = 0; mi < 256; mi += 17)
          apply(ops[k], 8'(mi), 8'(av), 8'(av ^ 8'h5A),
                {4'b1010, av[0], 2'b01, av[1]}, tag(ops[k]));

    // R4: incoming carry must not act as a borrow
    apply(8'hCB, 8'h01, 8'hFF, 8'h0F, 8'h00, "R4");
    apply(8'hCB, 8'h01, 8'hFF, 8'h0F, 8'h01, "R4");
    apply(8'hCB, 8'h10, 8'hFF, 8'h0F, 8'h00, "R4");
    apply(8'hCB, 8'h0F, 8'hFF, 8'h0F, 8'h01, "R4");

    // R8: decimal bit has no effect on BCD-looking operands
    apply(8'hEB, 8'h01, 8'h10, 8'h00, 8'h09, "R8");
    apply(8'hEB, 8'h01, 8'h10, 8'h00, 8'h01, "R8");
    apply(8'hEB, 8'h01, 8'h80, 8'h00, 8'h09, "R8");

    // R9: every opcode with odd register values
    for (int o = 0; o < 256; o++)
      apply(8'(o), 8'hC3, 8'h96, 8'h3C, 8'hE5, tag(8'(o)));

    // R11: default MAGIC ignores A; MAGIC=00 uses it
    for (int av = 0; av < 256; av += 5) begin
      apply(8'h8B, 8'hF0, 8'(av), 8'h3C, 8'h00, "R11");
      apply(8'hAB, 8'h5A, 8'(av), 8'h00, 8'h00, "R11");
      apply_m0(8'h8B, 8'hF0, 8'(av), 8'h3C, 8'h00);
      apply_m0(8'hAB, 8'h5A, 8'(av), 8'h00, 8'h00);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule